// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a small set of external interrupt input lines and turns each one into a request for an interrupt controller. Every line has its own enable bit and a two-bit sense field. The sense field picks rising-edge, falling-edge or low-level detection, or a reserved code that never requests. Inputs are brought into the system clock domain through a short flop chain before any clocked detection. The logic samples the line's value even when the same pin is being driven by the chip itself. Firmware can therefore raise an interrupt by driving its own pin.

In the edge modes a detected transition sets a sticky per-line flag. The line requests for as long as that flag is set and the line is enabled. Software clears a flag by pulsing a one on that line's clear bit. In level mode nothing is latched: the request follows the synchronized pin and stays up for as long as the pin is low. A separate wake output needs no clock. It is formed directly from the raw pins and rises whenever an enabled level-mode line is low. A low pulse too short to reach the synchronizer therefore still wakes the system but produces no request.

Top module: `exti_sense_unit`

## Requirements
- R1: After a synchronous active-low reset all flags and requests are 0. The synchronizer flops reset to 1, so a pin held high through reset produces no edge.
- R2: With sense code 2'b10 (falling edge), a high-to-low change on the pin sets that line's flag. The flag and the request (if enabled) become visible 3 clock edges after the change, and not earlier.
- R3: With sense code 2'b11 (rising edge), a low-to-high change sets the flag with the same 3-edge latency. A falling change in this mode sets nothing.
- R4: An edge flag is sticky. It stays set after the pin returns to its idle level, and an opposite transition does not affect it.
- R5: A one on bit k of `flag_clr_i` at a clock edge clears flag k at that edge. If a new matching edge is detected at the same edge, the flag stays set.
- R6: With sense code 2'b00 (low level), the request is high while the synchronized pin is low. It rises 2 edges after the pin falls, falls 2 edges after the pin rises, and never sets the flag.
- R7: Sense code 2'b01 is reserved. A line in that mode never sets its flag, never requests and never contributes to wake.
- R8: When a line's enable is 0, its request is 0, but edge events still set its flag. Setting the enable later raises the request from the stored flag without any clock delay.
- R9: `wake_o` is a combinational function of the raw pins. It is 1 exactly when some enabled line in level mode has its raw pin low, and it needs no clock edge.
- R10: Lines are independent. Simultaneous events on several lines set only the flags that match each line's own mode, and clearing one flag leaves the others unchanged.
- R11: A low pulse on a level-mode line that begins and ends between two clock edges asserts `wake_o` during the pulse but raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_LINES (4) | Raw external interrupt pins |
| enable_i | input | NUM_LINES (4) | Per-line request enable |
| sense_i | input | 2*NUM_LINES (8) | Per-line sense code, line k at bits [2k+1:2k] |
| flag_clr_i | input | NUM_LINES (4) | Write-one-to-clear strobe per edge flag |
| irq_o | output | NUM_LINES (4) | Per-line interrupt request |
| flag_o | output | NUM_LINES (4) | Per-line sticky edge flag |
| wake_o | output | 1 | Clockless wake indication from level-mode lines |

## Verification
The bench drives pins and controls on the falling clock edge. Each stimulus queues the values of `irq_o` and `flag_o` expected at the edge where the result is due. Edge results are due three rising edges after the pin change, level requests two edges after, a flag clear one edge after, and an enable change takes effect before the next edge. The bench also queues the previous-edge value on each edge case, so a design that reacts one cycle early is caught. A monitor counts rising edges and compares queued entries 2 ns after their due edge. `wake_o` is checked 1 ns after the pin changes, with no clock edge in between.

// File: rtl/exti_pkg.sv
// Package: shared types for the external interrupt sense unit.
// Assumes: every line uses a two-bit sense code with the encodings below.
package exti_pkg;

    // Per-line detection mode.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RSVD = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int unsigned SENSE_W = 2;

endpackage

// File: rtl/exti_sync.sv
// Module: exti_sync
// Brings one asynchronous pin into the clock domain through a flop chain.
// Assumes: STAGES >= 2; the flops reset to RESET_VAL so an idle pin gives no edge.
module exti_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    // First stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RESET_VAL;
        else        chain_q[0] <= d_i;
    end

    // Remaining stages shift the sample along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= RESET_VAL;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/exti_line.sv
// Module: exti_line
// One interrupt line: synchronizer, edge detector, sticky flag and request.
// Assumes: mode_i and enable_i are static software settings; clr_i is a
// one-cycle write-one-to-clear pulse. A new edge beats a clear in the same cycle.
module exti_line
    import exti_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  logic   enable_i,
    input  sense_e mode_i,
    input  logic   clr_i,
    output logic   req_o,
    output logic   flag_o
);

    logic pin_sync;
    logic prev_q;
    logic fell;
    logic rose;
    logic edge_hit;
    logic flag_q;
    logic cond;

    exti_sync #(
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (pin_i),
        .q_o  (pin_sync)
    );

    // Hold the synchronized value from one cycle earlier for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pin_sync;
    end

    assign fell = prev_q & ~pin_sync;
    assign rose = ~prev_q & pin_sync;

    // Pick the transition that counts in the selected mode.
    always_comb begin
        unique case (mode_i)
            SENSE_FALL: edge_hit = fell;
            SENSE_RISE: edge_hit = rose;
            default:    edge_hit = 1'b0;
        endcase
    end

    // Sticky flag: set on a matching edge, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (edge_hit) flag_q <= 1'b1;
        else if (clr_i)    flag_q <= 1'b0;
    end

    // Request source: flag in edge modes, live low level in level mode.
    always_comb begin
        unique case (mode_i)
            SENSE_LOW:              cond = ~pin_sync;
            SENSE_FALL, SENSE_RISE: cond = flag_q;
            default:                cond = 1'b0;
        endcase
    end

    assign req_o  = enable_i & cond;
    assign flag_o = flag_q;

    // R2/R3: the flag only rises after a matching transition.
    assert_flag_needs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(edge_hit));

    // R4: without an edge or a clear the flag keeps its value.
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_hit && !clr_i) |=> $stable(flag_q));

    // R5: a clear with no competing edge empties the flag.
    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !edge_hit) |=> !flag_q);

    // R5: an edge in the same cycle as a clear leaves the flag set.
    assert_edge_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_q);

    // R6: level mode never produces an edge event.
    assert_level_no_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_LOW) |-> !edge_hit);

    // R7: reserved mode never requests.
    assert_rsvd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == SENSE_RSVD) |-> !req_o);

    // R8: a disabled line never requests.
    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !req_o);

endmodule

// File: rtl/exti_wake.sv
// Module: exti_wake
// Clockless wake detect: any enabled level-mode line whose raw pin is low.
// Assumes: the consumer tolerates glitches; no flop sits on this path.
module exti_wake
    import exti_pkg::*;
#(
    parameter int unsigned NUM_LINES = 4,
    localparam int unsigned SENSE_BITS = SENSE_W * NUM_LINES
) (
    input  logic [NUM_LINES-1:0]  pin_i,
    input  logic [NUM_LINES-1:0]  enable_i,
    input  logic [SENSE_BITS-1:0] sense_i,
    output logic                  wake_o
);

    logic [NUM_LINES-1:0] low_hit;

    // One term per line: enabled, in level mode, raw pin low.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_term
        assign low_hit[k] = enable_i[k]
                          & (sense_e'(sense_i[SENSE_W*k +: SENSE_W]) == SENSE_LOW)
                          & ~pin_i[k];
    end

    assign wake_o = |low_hit;

endmodule

// File: rtl/exti_sense_unit.sv
// Module: exti_sense_unit
// Top of the external interrupt sense unit: one exti_line per pin plus the
// clockless wake combiner. Assumes pins idle high and settings change rarely.
module exti_sense_unit
    import exti_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned SENSE_BITS = SENSE_W * NUM_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pin_i,
    input  logic [NUM_LINES-1:0]  enable_i,
    input  logic [SENSE_BITS-1:0] sense_i,
    input  logic [NUM_LINES-1:0]  flag_clr_i,
    output logic [NUM_LINES-1:0]  irq_o,
    output logic [NUM_LINES-1:0]  flag_o,
    output logic                  wake_o
);

    // Per-line detection and request logic.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        exti_line #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[k]),
            .enable_i(enable_i[k]),
            .mode_i  (sense_e'(sense_i[SENSE_W*k +: SENSE_W])),
            .clr_i   (flag_clr_i[k]),
            .req_o   (irq_o[k]),
            .flag_o  (flag_o[k])
        );
    end

    exti_wake #(
        .NUM_LINES(NUM_LINES)
    ) u_wake (
        .pin_i   (pin_i),
        .enable_i(enable_i),
        .sense_i (sense_i),
        .wake_o  (wake_o)
    );

    // R9: wake only ever comes from an enabled line whose raw pin is low.
    assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> ((enable_i & ~pin_i) != '0));

endmodule

// File: tb/test_exti_sense_unit.sv
module test_exti_sense_unit;

    localparam int N = 4;

    typedef struct {
        int       due;
        logic [3:0] irq;
        logic [3:0] flg;
        string    tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin = 4'hF;
    logic [3:0] en = 4'hF;
    logic [7:0] sense = 8'b01_00_11_10; // line3 rsvd, line2 low, line1 rise, line0 fall
    logic [3:0] clr = 4'h0;
    logic [3:0] irq;
    logic [3:0] flg;
    logic       wake;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sbq[$];

    exti_sense_unit #(.NUM_LINES(N), .SYNC_STAGES(2)) i_exti_sense_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .enable_i  (en),
        .sense_i   (sense),
        .flag_clr_i(clr),
        .irq_o     (irq),
        .flag_o    (flg),
        .wake_o    (wake)
    );

    always #5 clk = ~clk;

    // Driver side: queue an expectation lat rising edges from now, kept sorted.
    function automatic void expect_at(int lat, logic [3:0] e_irq, logic [3:0] e_flg, string tag);
        exp_t e;
        int   pos;
        e.due = cyc + lat;
        e.irq = e_irq;
        e.flg = e_flg;
        e.tag = tag;
        pos = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].due > e.due) begin
                pos = i;
                break;
            end
        end
        sbq.insert(pos, e);
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // Immediate check of the clockless wake output.
    task automatic check_wake(logic e, string tag);
        #1;
        checks++;
        if (wake !== e) begin
            errors++;
            $display("FAIL %s wake_o actual=%b expected=%b", tag, wake, e);
        end
    endtask

    // Monitor: count edges and compare due entries shortly after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                e = sbq.pop_front();
                checks++;
                if (irq !== e.irq || flg !== e.flg) begin
                    errors++;
                    $display("FAIL %s cycle %0d irq/flag actual=%b/%b expected=%b/%b",
                             e.tag, cyc, irq, flg, e.irq, e.flg);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_at(1, 4'h0, 4'h0, "R1 reset state");
        expect_at(3, 4'h0, 4'h0, "R1 no edge after reset");
        tick(4);

        // R2: falling edge on line0, exact latency.
        pin[0] = 1'b0;
        expect_at(2, 4'h0, 4'h0, "R2 not early");
        expect_at(3, 4'h1, 4'h1, "R2 falling sets");
        tick(4);

        // R4: return high, flag stays.
        pin[0] = 1'b1;
        expect_at(4, 4'h1, 4'h1, "R4 sticky");
        tick(5);

        // R5: clear.
        clr = 4'h1;
        expect_at(1, 4'h0, 4'h0, "R5 clear");
        tick(1);
        clr = 4'h0;
        tick(3);

        // R3: rising mode on line1.
        pin[1] = 1'b0;
        expect_at(4, 4'h0, 4'h0, "R3 falling ignored");
        tick(4);
        pin[1] = 1'b1;
        expect_at(2, 4'h0, 4'h0, "R3 not early");
        expect_at(3, 4'h2, 4'h2, "R3 rising sets");
        tick(4);
        clr = 4'h2;
        expect_at(1, 4'h0, 4'h0, "R3 clear");
        tick(1);
        clr = 4'h0;
        tick(3);

        // R6 + R9: level mode on line2.
        pin[2] = 1'b0;
        check_wake(1'b1, "R9 wake on low");
        expect_at(1, 4'h0, 4'h0, "R6 not early");
        expect_at(2, 4'h4, 4'h0, "R6 level request");
        tick(5);
        expect_at(1, 4'h4, 4'h0, "R6 level held");
        tick(2);
        pin[2] = 1'b1;
        check_wake(1'b0, "R9 wake released");
        expect_at(1, 4'h4, 4'h0, "R6 drop not early");
        expect_at(2, 4'h0, 4'h0, "R6 level drops");
        tick(4);

        // R7: reserved line3.
        pin[3] = 1'b0;
        check_wake(1'b0, "R7 reserved no wake");
        expect_at(3, 4'h0, 4'h0, "R7 reserved fall");
        tick(4);
        pin[3] = 1'b1;
        expect_at(3, 4'h0, 4'h0, "R7 reserved rise");
        tick(4);

        // R8: disabled line still flags, enable exposes it.
        en = 4'hE;
        pin[0] = 1'b0;
        expect_at(3, 4'h0, 4'h1, "R8 flag while disabled");
        tick(4);
        pin[0] = 1'b1;
        en = 4'hF;
        expect_at(1, 4'h1, 4'h1, "R8 enable shows flag");
        tick(2);
        clr = 4'h1;
        expect_at(1, 4'h0, 4'h0, "R8 clear");
        tick(1);
        clr = 4'h0;
        tick(2);

        // R5: edge and clear at the same edge.
        pin[0] = 1'b0;
        expect_at(3, 4'h1, 4'h1, "R5 setup");
        tick(4);
        pin[0] = 1'b1;
        tick(3);
        pin[0] = 1'b0;
        tick(2);
        clr = 4'h1;
        expect_at(1, 4'h1, 4'h1, "R5 edge beats clear");
        tick(1);
        clr = 4'h0;
        expect_at(2, 4'h1, 4'h1, "R5 stays set");
        tick(2);
        pin[0] = 1'b1;
        clr = 4'h1;
        expect_at(1, 4'h0, 4'h0, "R5 later clear");
        tick(1);
        clr = 4'h0;
        tick(2);

        // R10: simultaneous events, selective clear.
        pin[1:0] = 2'b00;
        expect_at(3, 4'h1, 4'h1, "R10 only line0 on fall");
        tick(4);
        pin[1:0] = 2'b11;
        expect_at(3, 4'h3, 4'h3, "R10 line1 on rise");
        tick(4);
        clr = 4'h1;
        expect_at(1, 4'h2, 4'h2, "R10 clear one line");
        tick(1);
        clr = 4'h2;
        expect_at(1, 4'h0, 4'h0, "R10 clear other");
        tick(1);
        clr = 4'h0;
        tick(2);

        // R11: short low pulse between edges.
        #1 pin[2] = 1'b0;
        check_wake(1'b1, "R11 wake on glitch");
        #1 pin[2] = 1'b1;
        expect_at(1, 4'h0, 4'h0, "R11 no request");
        expect_at(2, 4'h0, 4'h0, "R11 no request");
        expect_at(3, 4'h0, 4'h0, "R11 no request");
        tick(4);

        // R9: disabled level line gives no wake.
        en = 4'hB;
        pin[2] = 1'b0;
        check_wake(1'b0, "R9 disabled no wake");
        expect_at(2, 4'h0, 4'h0, "R9 disabled no request");
        tick(3);
        pin[2] = 1'b1;
        tick(3);
        en = 4'hF;
        tick(5);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard residue actual=%0d expected=0", sbq.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule